// File: doc/BRIEF.md
# Memory-Paced Word Sequencer with Inline Stall Counts

This controller streams words out of an external read-only memory in address order. The stream is cut into fixed-size groups. After each group of payload words, the next memory word is not passed on. Its low byte is taken as a stall length, and the controller then idles for exactly that many clock cycles before it reads the next group. The pattern continues without end. When the address reaches the last memory location, it returns to zero.

The memory is assumed to be synchronous with one cycle of read latency. The controller drives an address in one cycle and takes the returned word at the next edge, so each word costs two cycles. Payload words are presented on a registered output together with a one-cycle valid strobe. A separate output is high for the whole of a stall. Every piece of state lives in flip-flops that an active-high asynchronous reset clears.

Top module: `rom_delay_seq`

## Requirements
- R1: While reset is high, and at once when it rises, the address output is 0, the word output is 0, and both the valid strobe and the stall indicator are low.
- R2: Each memory word is read in two cycles. The address is held for one cycle, then the word is taken and the address goes up by one.
- R3: The first GROUP_LEN words of every group are payload. Each is put on the word output with the valid strobe high for exactly one cycle, in the cycle after it is taken.
- R4: The word after a group is a stall word. Bits [DLY_W-1:0] give the stall length and the upper bits are ignored. Taking it never raises the valid strobe and never changes the word output.
- R5: A stall word of value N>0 keeps the stall indicator high for exactly N consecutive cycles. No address change or capture happens during that time. Reading resumes in the cycle after.
- R6: A stall word of value 0 causes no stall cycle. The next address is issued in the cycle right after the stall word is taken.
- R7: After the word at address ROM_DEPTH-1 is taken, the address becomes 0.
- R8: When the valid strobe is low, the word output keeps its previous value.
- R9: The group-then-stall pattern repeats continuously across the address wrap, with the group position carried on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| rom_addr | output | ADDR_W | Read address to the memory |
| rom_rdata | input | DATA_W | Word returned by the memory one cycle after the address |
| word_out | output | DATA_W | Last payload word captured |
| word_vld | output | 1 | One-cycle strobe for a new payload word |
| stalling | output | 1 | High during each stall cycle |

## Verification
Two events can land on the same clock edge: the address wrap and the capture of a stall word. The bench places the longest stall (255) at the last memory location, so the return to address 0 and the start of the stall happen on one edge. The post-stall address must then be 0 after exactly 255 indicator cycles. Zero-length stall words are also in the stream, so capturing a stall word and resuming the read fall on the same edge; the bench checks that no stall cycle appears between them. Each output is compared against a behavioural timeline built from the memory contents on every cycle, and this includes a reset applied mid-stream.

// File: rtl/rds_pkg.sv
package rds_pkg;

    typedef enum logic [1:0] {
        PH_ISSUE = 2'd0,
        PH_TAKE  = 2'd1,
        PH_STALL = 2'd2
    } phase_e;

    typedef struct packed {
        logic adv_addr;
        logic take_data;
        logic take_delay;
        logic tick;
    } step_ctl_t;

    function automatic logic [31:0] wrap_next(input logic [31:0] cur, input logic [31:0] last);
        return (cur == last) ? 32'd0 : cur + 32'd1;
    endfunction

endpackage

// File: rtl/rds_addr_ctr.sv
module rds_addr_ctr #(
    parameter int ADDR_W    = 6,
    parameter int ROM_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    import rds_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ROM_DEPTH - 1);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q <= '0;
        end else if (adv) begin
            addr_q <= ADDR_W'(wrap_next(32'(addr_q), 32'(LAST)));
        end
    end

    assign addr = addr_q;

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        addr_q <= LAST);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr_q) |-> (addr_q == (($past(addr_q) == LAST) ? '0 : $past(addr_q) + 1'b1)));

endmodule

// File: rtl/rds_stall_timer.sv
module rds_stall_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             done
);
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dly_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            dly_q <= load_val;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == dly_q - 1'b1);

    // R5
    stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt_q < dly_q));

endmodule

// File: rtl/rds_word_reg.sv
module rds_word_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              vld
);
    logic [DATA_W-1:0] data_q;
    logic              vld_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= take;
            if (take) begin
                data_q <= din;
            end
        end
    end

    assign dout = data_q;
    assign vld  = vld_q;

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_q |-> $stable(data_q));

    // R3
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);

endmodule

// File: rtl/rom_delay_seq.sv
module rom_delay_seq
    import rds_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DLY_W     = 8,
    parameter int ADDR_W    = 6,
    parameter int ROM_DEPTH = 64,
    parameter int GROUP_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [DATA_W-1:0] word_out,
    output logic              word_vld,
    output logic              stalling
);
    localparam int              GRP_W    = $clog2(GROUP_LEN + 1);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP_LEN);

    phase_e            phase_q, phase_d;
    logic [GRP_W-1:0]  grp_q, grp_d;
    step_ctl_t         ctl;
    logic [DLY_W-1:0]  dly_word;
    logic              dly_zero;
    logic              stall_done;

    assign dly_word = rom_rdata[DLY_W-1:0];
    assign dly_zero = (dly_word == '0);

    always_comb begin
        ctl     = '0;
        phase_d = phase_q;
        grp_d   = grp_q;
        case (phase_q)
            PH_ISSUE: phase_d = PH_TAKE;
            PH_TAKE: begin
                ctl.adv_addr = 1'b1;
                if (grp_q == GRP_LAST) begin
                    ctl.take_delay = 1'b1;
                    grp_d          = '0;
                    phase_d        = dly_zero ? PH_ISSUE : PH_STALL;
                end else begin
                    ctl.take_data = 1'b1;
                    grp_d         = grp_q + 1'b1;
                    phase_d       = PH_ISSUE;
                end
            end
            PH_STALL: begin
                ctl.tick = 1'b1;
                if (stall_done) begin
                    phase_d = PH_ISSUE;
                end
            end
            default: phase_d = PH_ISSUE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase_q <= PH_ISSUE;
            grp_q   <= '0;
        end else begin
            phase_q <= phase_d;
            grp_q   <= grp_d;
        end
    end

    rds_addr_ctr #(
        .ADDR_W    (ADDR_W),
        .ROM_DEPTH (ROM_DEPTH)
    ) addr_ctr_i (
        .clk  (clk),
        .rst  (rst),
        .adv  (ctl.adv_addr),
        .addr (rom_addr)
    );

    rds_stall_timer #(
        .DLY_W (DLY_W)
    ) stall_timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.take_delay),
        .load_val (dly_word),
        .tick     (ctl.tick),
        .done     (stall_done)
    );

    rds_word_reg #(
        .DATA_W (DATA_W)
    ) word_reg_i (
        .clk  (clk),
        .rst  (rst),
        .take (ctl.take_data),
        .din  (rom_rdata),
        .dout (word_out),
        .vld  (word_vld)
    );

    assign stalling = (phase_q == PH_STALL);

    // R4
    vld_not_stall_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> !stalling);

    // R6
    zero_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAKE && grp_q == GRP_LAST && dly_zero) |=> !stalling);

    // R5
    stall_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(stalling) && stalling) |-> $stable(rom_addr));

endmodule

// File: tb/rom_delay_seq_tb_top.sv
module rom_delay_seq_tb_top;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int DEPTH = 16;
    localparam int GL = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_rdata;
    logic [DW-1:0] word_out;
    logic          word_vld;
    logic          stalling;

    logic [DW-1:0] rom [DEPTH];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int    q_addr[$];
    bit    q_vld[$];
    bit    q_stall[$];
    logic [DW-1:0] q_data[$];
    string q_tag[$];

    always #5 clk = ~clk;

    always_ff @(posedge clk) rom_rdata <= rom[rom_addr[3:0]];

    rom_delay_seq #(
        .DATA_W(DW), .DLY_W(8), .ADDR_W(AW), .ROM_DEPTH(DEPTH), .GROUP_LEN(GL)
    ) dut_i (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .word_out(word_out), .word_vld(word_vld), .stalling(stalling)
    );

    function automatic int stall_of(int g);
        case (g)
            0: return 0;
            1: return 1;
            2: return 5;
            default: return 255;
        endcase
    endfunction

    task automatic push(int a, bit v, bit s, logic [DW-1:0] d, string t);
        q_addr.push_back(a); q_vld.push_back(v); q_stall.push_back(s);
        q_data.push_back(d); q_tag.push_back(t);
    endtask

    // Behavioural timeline of outputs after every clock edge following reset release
    task automatic build(int passes);
        logic [DW-1:0] held = '0;
        q_addr.delete(); q_vld.delete(); q_stall.delete(); q_data.delete(); q_tag.delete();
        for (int p = 0; p < passes; p++) begin
            for (int i = 0; i < DEPTH; i++) begin
                int na = (i == DEPTH - 1) ? 0 : i + 1;
                push(i, 0, 0, held, "R8");
                if ((i % (GL + 1)) < GL) begin
                    held = rom[i];
                    push(na, 1, 0, held, (p > 0) ? "R9" : "R3");
                end else begin
                    int d = int'(rom[i][7:0]);
                    if (d == 0) begin
                        push(na, 0, 0, held, "R6");
                    end else begin
                        push(na, 0, 1, held, "R4");
                        for (int k = 1; k < d; k++) push(na, 0, 1, held, "R5");
                        push(na, 0, 0, held, "R5");
                    end
                end
            end
        end
    endtask

    task automatic check_reset();
        checks++;
        if (rom_addr !== '0 || word_out !== '0 || word_vld !== 1'b0 || stalling !== 1'b0) begin
            errors++;
            $display("FAIL R1: addr=%0d data=%h vld=%b stall=%b expected 0/0/0/0",
                     rom_addr, word_out, word_vld, stalling);
        end
    endtask

    task automatic run_queue();
        while (q_addr.size() > 0) begin
            int a = q_addr.pop_front();
            bit v = q_vld.pop_front();
            bit s = q_stall.pop_front();
            logic [DW-1:0] d = q_data.pop_front();
            string t = q_tag.pop_front();
            string at = (a == 0) ? "R7" : "R2";
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (int'(rom_addr) != a) begin
                errors++;
                $display("FAIL %s: rom_addr=%0d expected %0d", at, rom_addr, a);
            end else if (word_vld !== v) begin
                errors++;
                $display("FAIL %s: word_vld=%b expected %b", t, word_vld, v);
            end else if (stalling !== s) begin
                errors++;
                $display("FAIL %s: stalling=%b expected %b", t, stalling, s);
            end else if (word_out !== d) begin
                errors++;
                $display("FAIL %s: word_out=%h expected %h", t, word_out, d);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            if ((i % (GL + 1)) == GL)
                rom[i] = 32'hDEAD_BE00 | 32'(stall_of(i / (GL + 1)));
            else
                rom[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0307);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset();
        build(2);
        rst = 1'b0;
        run_queue();
        // mid-stream reset, taken while a stall or read is in progress
        repeat (7) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        #1;
        check_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset();
        build(1);
        rst = 1'b0;
        run_queue();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule